// File: doc/BRIEF.md
# Cascadable LCD Segment Data Loader

This block is the digital core of a 160-column LCD segment driver. A display controller presents 4-bit nibbles together with a data clock. On each falling edge of that data clock the block stores one nibble into a wide input latch. A direction input sets the order in which columns fill: from the last column toward the first, or from the first toward the last. Several identical loaders share one data bus and form a chain through a pair of active-low enable pins. The direction input also swaps which pin of the pair is the input and which is the output. A loader captures only while its enable input is low. It pulls its enable output low once it has taken a full line, which hands the bus to the next loader in the chain.

A falling edge on the load strobe copies the whole input latch into the output latch. The same edge rewinds the capture counter, so a new line can start. For every column, a 2-bit drive-level code is formed from three things: the latched data bit, an AC frame input and an active-low blanking input. The analog stage uses this code to pick one of four bias levels.

All inputs are sampled on the system clock `clk`. The edges of the data clock and of the load strobe are detected from the previous sampled value of each input.

Top module: `lcdseg_loader`

## Requirements
- R1: After reset, the capture counter is empty and both enable outputs are high. Both latches hold zeros, so with `frame`=0 and `blankN`=1 every column shows code 01.
- R2: A nibble is captured only in a `clk` cycle where `dataClk` is seen low after being high, and only while the selected enable input is low. Rising edges, and falling edges seen while that enable input is high, leave the latch and the counter unchanged.
- R3: With `dirHigh`=0, the k-th captured nibble (k=0..39) places bit j of `nibble` on column 157-4k+j, with columns numbered 1..160. So the first nibble fills columns 157..160 and the 40th fills columns 1..4.
- R4: With `dirHigh`=1, the k-th captured nibble places bit j on column 4k+4-j. So bit 0 of the first nibble lands on column 4, and bit 0 of the 40th lands on column 160.
- R5: With `dirHigh`=0, `enBIn` is the enable input and pin A is the output (`enAOe`=1, `enBOe`=0). With `dirHigh`=1 the roles swap. The pin that is not selected as input has no effect.
- R6: The cycle after the 40th nibble is captured, the enable output goes low. From then on, further data-clock edges are ignored until a load.
- R7: One cycle after a falling edge of `loadStrobe`, the output latch holds the whole input latch. Between loads, the output latch and `levelCode` do not follow new captures.
- R8: A load falling edge returns the enable output high and restarts capture at nibble 0. If a data-clock falling edge is seen in the same cycle as a load falling edge, the load wins and that nibble is dropped.
- R9: Column c drives `levelCode[2c-1:2c-2]` as follows: data 0 with frame 0 gives 01, data 1 with frame 0 gives 00, data 0 with frame 1 gives 10, and data 1 with frame 1 gives 11. The code follows `frame` within the same cycle.
- R10: While `blankN` is low, every column code is 00, whatever the data and the frame.
- R11: `idle` is high whenever the loader cannot capture: either its selected enable input is high or it already holds a full line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataClk | input | 1 | Data clock; a nibble is taken on its falling edge |
| loadStrobe | input | 1 | Line load; acts on its falling edge |
| dirHigh | input | 1 | Fill direction and role of the enable pins |
| nibble | input | 4 | Parallel display data |
| enAIn | input | 1 | Enable pin A, input side |
| enBIn | input | 1 | Enable pin B, input side |
| frame | input | 1 | AC frame polarity |
| blankN | input | 1 | Active-low blanking; low forces code 00 |
| enAOut | output | 1 | Enable pin A, output side |
| enBOut | output | 1 | Enable pin B, output side |
| enAOe | output | 1 | Pin A is currently the output |
| enBOe | output | 1 | Pin B is currently the output |
| idle | output | 1 | Loader is not capturing |
| levelCode | output | 320 | Two-bit drive code per column, column 1 in bits 1:0 |

## Verification
A data-clock or load falling edge that is driven between clock edges is seen at the next rising edge of `clk`. The counter, the enable output and the latches therefore change at that edge. `levelCode` follows the output latch, `frame` and `blankN` through logic only, so a frame or blank change is visible before the next edge. Every stimulus task drives its inputs on a falling edge of `clk`, waits one full clock past the edge that acts on it, and samples on the following falling edge. A reference latch image in the bench is updated by the same tasks, using the column formulas of R3 and R4.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // store the current nibble at the current beat
    logic load;     // copy input latch to output latch
    logic dirHigh;  // column fill direction
  } ctrlStrb_t;

  // Drive-level codes
  typedef enum logic [1:0] {
    LVL_SEL_POS = 2'b00,
    LVL_NON_POS = 2'b01,
    LVL_NON_NEG = 2'b10,
    LVL_SEL_NEG = 2'b11
  } level_t;
endpackage

// File: rtl/lcdseg_ctrl.sv
module lcdseg_ctrl
  import lcdseg_pkg::*;
#(
  parameter int COLS = 160,
  parameter int NIB  = 4,
  localparam int BEATS  = COLS / NIB,
  localparam int BEAT_W = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataClk,
  input  logic              loadStrobe,
  input  logic              dirHigh,
  input  logic              enAIn,
  input  logic              enBIn,
  output ctrlStrb_t         strb,
  output logic [BEAT_W-1:0] beat,
  output logic              enAOut,
  output logic              enBOut,
  output logic              enAOe,
  output logic              enBOe,
  output logic              idle
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);
  localparam logic [BEAT_W-1:0] FULL = BEAT_W'(BEATS);

  logic dclkPrev, loadPrev;
  logic dFall, lFall;
  logic enIn, armed, capture;
  logic done;
  logic [BEAT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dclkPrev <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      dclkPrev <= dataClk;
      loadPrev <= loadStrobe;
    end
  end

  assign dFall   = dclkPrev & ~dataClk;
  assign lFall   = loadPrev & ~loadStrobe;
  assign enIn    = dirHigh ? enAIn : enBIn;
  assign armed   = ~enIn & ~done;
  assign capture = dFall & armed & ~lFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (lFall) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (capture) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

  assign strb.capture = capture;
  assign strb.load    = lFall;
  assign strb.dirHigh = dirHigh;
  assign beat         = cnt;

  assign enAOut = dirHigh ? 1'b1 : ~done;
  assign enBOut = dirHigh ? ~done : 1'b1;
  assign enAOe  = ~dirHigh;
  assign enBOe  = dirHigh;
  assign idle   = ~armed;

  // R6
  full_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cnt == FULL));
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL);
  // R8
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    lFall |=> (cnt == '0 && !done));
  // R2
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && !lFall) |=> $stable(cnt));
endmodule

// File: rtl/lcdseg_datapath.sv
module lcdseg_datapath
  import lcdseg_pkg::*;
#(
  parameter int COLS = 160,
  parameter int NIB  = 4,
  localparam int BEATS  = COLS / NIB,
  localparam int BEAT_W = $clog2(BEATS + 1),
  localparam int IDX_W  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [BEAT_W-1:0] beat,
  input  logic [NIB-1:0]    nibble,
  input  logic              frame,
  input  logic              blankN,
  output logic [2*COLS-1:0] levelCode
);
  logic [COLS-1:0] inLatch;
  logic [COLS-1:0] outLatch;
  logic [IDX_W-1:0] baseLow, baseHigh;

  // Lowest written bit index for each direction
  assign baseLow  = IDX_W'(COLS - NIB) - IDX_W'(NIB * beat);
  assign baseHigh = IDX_W'(NIB * beat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inLatch <= '0;
    end else if (strb.capture) begin
      for (int j = 0; j < NIB; j++) begin
        if (strb.dirHigh) inLatch[baseHigh + IDX_W'(NIB - 1 - j)] <= nibble[j];
        else              inLatch[baseLow + IDX_W'(j)]            <= nibble[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outLatch <= '0;
    else if (strb.load) outLatch <= inLatch;
  end

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      level_t lvl;
      always_comb begin
        if (!blankN)         lvl = LVL_SEL_POS;
        else if (!frame)     lvl = outLatch[c] ? LVL_SEL_POS : LVL_NON_POS;
        else                 lvl = outLatch[c] ? LVL_SEL_NEG : LVL_NON_NEG;
      end
      assign levelCode[2*c +: 2] = lvl;
    end
  endgenerate

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(outLatch));
  // R7
  out_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (outLatch == $past(inLatch)));
  // R8
  load_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> $stable(inLatch));
endmodule

// File: rtl/lcdseg_loader.sv
module lcdseg_loader
  import lcdseg_pkg::*;
#(
  parameter int COLS = 160,
  parameter int NIB  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataClk,
  input  logic              loadStrobe,
  input  logic              dirHigh,
  input  logic [NIB-1:0]    nibble,
  input  logic              enAIn,
  input  logic              enBIn,
  input  logic              frame,
  input  logic              blankN,
  output logic              enAOut,
  output logic              enBOut,
  output logic              enAOe,
  output logic              enBOe,
  output logic              idle,
  output logic [2*COLS-1:0] levelCode
);
  localparam int BEATS  = COLS / NIB;
  localparam int BEAT_W = $clog2(BEATS + 1);

  ctrlStrb_t         strb;
  logic [BEAT_W-1:0] beat;

  lcdseg_ctrl #(.COLS(COLS), .NIB(NIB)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataClk(dataClk), .loadStrobe(loadStrobe),
    .dirHigh(dirHigh), .enAIn(enAIn), .enBIn(enBIn), .strb(strb), .beat(beat),
    .enAOut(enAOut), .enBOut(enBOut), .enAOe(enAOe), .enBOe(enBOe), .idle(idle)
  );

  lcdseg_datapath #(.COLS(COLS), .NIB(NIB)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .beat(beat), .nibble(nibble),
    .frame(frame), .blankN(blankN), .levelCode(levelCode)
  );
endmodule

// File: tb/tb_lcdseg_loader.sv
module tb_lcdseg_loader;
  localparam int COLS = 160;
  localparam int NIB  = 4;
  localparam int BEATS = COLS / NIB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataClk = 1'b0, loadStrobe = 1'b0, dirHigh = 1'b0;
  logic [NIB-1:0] nibble = '0;
  logic enAIn = 1'b1, enBIn = 1'b1, frame = 1'b0, blankN = 1'b1;
  logic enAOut, enBOut, enAOe, enBOe, idle;
  logic [2*COLS-1:0] levelCode;

  int testCnt = 0, failCnt = 0;
  logic [COLS-1:0] modelIn = '0, modelOut = '0;
  int bCnt = 0;
  bit bDone = 0;

  always #2.5 clk = ~clk;

  lcdseg_loader #(.COLS(COLS), .NIB(NIB)) dut (
    .clk(clk), .rstN(rstN), .dataClk(dataClk), .loadStrobe(loadStrobe),
    .dirHigh(dirHigh), .nibble(nibble), .enAIn(enAIn), .enBIn(enBIn),
    .frame(frame), .blankN(blankN), .enAOut(enAOut), .enBOut(enBOut),
    .enAOe(enAOe), .enBOe(enBOe), .idle(idle), .levelCode(levelCode)
  );

  function automatic logic [1:0] expCode(logic d, logic f, logic b);
    if (!b) return 2'b00;
    case ({d, f})
      2'b00: return 2'b01;
      2'b10: return 2'b00;
      2'b01: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkLevels(string req);
    int bad = -1;
    logic [1:0] a = '0, e = '0;
    for (int c = 0; c < COLS; c++) begin
      if (bad < 0 && levelCode[2*c +: 2] !== expCode(modelOut[c], frame, blankN)) begin
        bad = c; a = levelCode[2*c +: 2]; e = expCode(modelOut[c], frame, blankN);
      end
    end
    testCnt++;
    if (bad >= 0) begin
      failCnt++;
      $display("FAIL %s column %0d actual=%0b expected=%0b", req, bad + 1, a, e);
    end
  endtask

  // one data-clock pulse; the model follows R2/R3/R4/R6
  task automatic pulseData(logic [NIB-1:0] nib);
    logic act;
    @(negedge clk);
    nibble = nib; dataClk = 1'b1;
    @(negedge clk);
    dataClk = 1'b0;
    @(negedge clk);
    act = ((dirHigh ? enAIn : enBIn) == 1'b0) && !bDone;
    if (act) begin
      for (int j = 0; j < NIB; j++) begin
        int col = dirHigh ? (NIB*bCnt + NIB - j) : (COLS - 3 - NIB*bCnt + j);
        modelIn[col-1] = nib[j];
      end
      bCnt++;
      if (bCnt == BEATS) bDone = 1;
    end
  endtask

  task automatic pulseLoad(bit withData, logic [NIB-1:0] nib);
    @(negedge clk);
    loadStrobe = 1'b1;
    if (withData) begin nibble = nib; dataClk = 1'b1; end
    @(negedge clk);
    loadStrobe = 1'b0;
    dataClk = 1'b0;
    @(negedge clk);
    modelOut = modelIn; bCnt = 0; bDone = 0;
  endtask

  task automatic fill(int n);
    for (int i = 0; i < n; i++) pulseData(NIB'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkLevels("R1 reset levels");
    check("R1 enable outputs", {enAOut, enBOut}, 2'b11);
    check("R11 idle with enable high", idle, 1'b1);

    // R2 enable input high: pulses ignored
    fill(6);
    pulseLoad(0, '0);
    checkLevels("R2 gated pulses ignored");

    // R5 dir low: pin A input has no effect
    dirHigh = 0; enAIn = 0; enBIn = 1;
    @(negedge clk);
    check("R5 oe dir low", {enAOe, enBOe}, 2'b10);
    check("R11 idle when pin B high", idle, 1'b1);
    fill(3);
    pulseLoad(0, '0);
    checkLevels("R5 unselected pin ignored");

    // R3 dir low fill
    enAIn = 1; enBIn = 0;
    @(negedge clk);
    check("R11 capturing not idle", idle, 1'b0);
    fill(BEATS - 1);
    check("R6 output high before last", enAOut, 1'b1);
    checkLevels("R7 no update before load");
    fill(1);
    check("R6 output low after last", enAOut, 1'b0);
    check("R11 idle when full", idle, 1'b1);
    fill(2);   // ignored per R6
    pulseLoad(0, '0);
    checkLevels("R3 dir low mapping");
    check("R8 output high after load", enAOut, 1'b1);

    // R9 frame and R10 blanking
    frame = 1; #1;
    checkLevels("R9 frame 1 codes");
    frame = 0; #1;
    checkLevels("R9 frame 0 codes");
    blankN = 0; #1;
    checkLevels("R10 blank forces 00");
    check("R10 column 1 code", levelCode[1:0], 2'b00);
    blankN = 1;

    // R4 dir high, directed first nibble then random
    dirHigh = 1; enAIn = 0; enBIn = 1;
    @(negedge clk);
    check("R5 oe dir high", {enAOe, enBOe}, 2'b01);
    pulseData(4'b0001);
    fill(BEATS - 1);
    check("R6 pin B low after last", enBOut, 1'b0);
    check("R5 pin A idle high", enAOut, 1'b1);
    pulseLoad(0, '0);
    checkLevels("R4 dir high mapping");
    check("R4 column 4 selected", levelCode[7:6], 2'b00);
    check("R4 column 1 not selected", levelCode[1:0], 2'b01);

    // R8 load with simultaneous data edge drops the nibble
    fill(5);
    pulseLoad(1, 4'hF);
    fill(BEATS);
    pulseLoad(0, '0);
    checkLevels("R8 simultaneous edge dropped");

    // random lines in both directions with random frame
    for (int r = 0; r < 6; r++) begin
      dirHigh = r[0];
      enAIn = ~r[0]; enBIn = r[0];
      fill(BEATS);
      pulseLoad(0, '0);
      frame = 1'($urandom);
      #1;
      checkLevels(r[0] ? "R4 random line" : "R3 random line");
      frame = 0;
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule